// File: doc/BRIEF.md
# Dual-Channel Register Bus Decoder

This block is the processor-facing front end of a two-channel serial controller. A host drives an 8-bit data bus, a 3-bit register offset, an active-low select, a channel selector and separate active-low read and write strobes. The block steers each access to one of two identical register banks, one per channel, each holding eight byte-wide registers. The serial engines behind the banks are not part of the block; the banks stand in for them.

Reads are combinational. The bank chosen by the channel selector drives the data output, and an output-enable marks the cycles in which the bus would be driven. Writes are committed once per strobe pulse, when the write strobe returns high, using the select, channel, offset and data captured during the last clock in which the strobe was low. A broadcast bit in each channel's alternate function register turns writes into an update of the same offset in both banks. Each channel also combines five interrupt conditions, gated by its own enable register, into one active-high request.

Top module: `dual_chan_bus_front`

## Requirements
- R1: After synchronous reset every register in both banks reads 0x00, and both interrupt outputs are low whatever the interrupt sources are.
- R2: `bus_oe` is high only while `cs_n` and `rd_n` are both low; at all other times it is low.
- R3: During a read, `bus_out` shows the register at `reg_off` of channel A when `chan_sel` is 1 and of channel B when `chan_sel` is 0.
- R4: A write is committed at the first rising clock edge at which `wr_n` is seen high after having been low. It uses the `cs_n`, `chan_sel`, `reg_off` and `bus_in` values sampled at the last clock edge while `wr_n` was low. Each strobe pulse gives exactly one update, and bus activity outside the strobe changes nothing.
- R5: A write strobe during which `cs_n` was high at the last sampled low-strobe edge changes no register.
- R6: With broadcast off, a write changes only the addressed register of the channel picked by `chan_sel`. The other channel is untouched.
- R7: Offset 2 is the alternate function register. When its bit 0 is set in the channel that `chan_sel` addresses at the time of the write, the write updates the same offset in both channels. The other channel's bit 0 plays no part.
- R8: Broadcast has no effect on reads. A read always returns the bank chosen by `chan_sel`.
- R9: Offset 1 is the interrupt enable register. The interrupt output of a channel is high exactly when some bit of its 5-bit source input is high and the same bit of that channel's enable register is set. Source bits: 0 receive data ready, 1 receive timeout, 2 receive error, 3 transmit empty, 4 modem status change. The output follows the sources combinationally.
- R10: The eight offsets of a channel are independent storage locations. Each keeps the byte last written to it, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low access select |
| chan_sel | input | 1 | 1 addresses channel A, 0 addresses channel B |
| reg_off | input | 3 | Register offset within the channel |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_in | input | 8 | Write data from the host |
| bus_out | output | 8 | Read data toward the host |
| bus_oe | output | 1 | High when the host bus would be driven |
| src_a | input | 5 | Channel A interrupt conditions |
| src_b | input | 5 | Channel B interrupt conditions |
| irq_a | output | 1 | Channel A interrupt request, active high |
| irq_b | output | 1 | Channel B interrupt request, active high |

## Verification
Writes are applied to each channel alone, with the select inactive, and over all eight offsets. Read-backs of both banks separate steering mistakes from swapped channels and from aliasing between offsets. Broadcast is exercised from channel A with channel B's bit clear, and then from channel B while A's bit is still set, which shows that only the addressed channel's bit governs. A long strobe whose data changes mid-pulse, followed by data toggling after release, pins down the single commit and the sample point. Source and enable patterns that overlap and that miss each other check the interrupt gating on both outputs.

// File: rtl/dcbf_pkg.sv
package dcbf_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int NUM_CH    = 2;
    localparam int NUM_SRC   = 5;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int IER_OFF   = 1;
    localparam int AFR_OFF   = 2;
    localparam int BCAST_BIT = 0;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] roff_t;
    typedef logic [NUM_SRC-1:0] src_t;
    typedef logic [NUM_REGS-1:0][DATA_W-1:0] bank_t;

    // channel index used throughout the datapath
    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    // a write captured during the low phase of the strobe
    typedef struct packed {
        logic  sel;
        chan_e chan;
        roff_t off;
        byte_t data;
    } wr_cap_t;

    // a write ready to be applied
    typedef struct packed {
        logic  go;
        chan_e chan;
        roff_t off;
        byte_t data;
    } wr_req_t;

    function automatic chan_e decode_chan(input logic chan_sel);
        return chan_sel ? CH_A : CH_B;
    endfunction

    function automatic logic gate_irq(input src_t src, input byte_t enables);
        return |(src & enables[NUM_SRC-1:0]);
    endfunction

endpackage

// File: rtl/dcbf_wr_capture.sv
module dcbf_wr_capture
    import dcbf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    chan_sel,
    input  roff_t   reg_off,
    input  byte_t   bus_in,
    input  logic    wr_n,
    output wr_req_t req
);

    logic    wr_q;
    wr_cap_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b1;
            held <= '0;
        end else begin
            wr_q <= wr_n;
            if (!wr_n) begin
                held.sel  <= ~cs_n;
                held.chan <= decode_chan(chan_sel);
                held.off  <= reg_off;
                held.data <= bus_in;
            end
        end
    end

    // commit on the first edge that sees the strobe released
    always_comb begin
        req.go   = held.sel && !wr_q && wr_n;
        req.chan = held.chan;
        req.off  = held.off;
        req.data = held.data;
    end

endmodule

// File: rtl/dcbf_bank.sv
module dcbf_bank
    import dcbf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  roff_t waddr,
    input  byte_t wdata,
    input  src_t  src,
    output bank_t regs,
    output logic  irq
);

    bank_t store;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                store[r] <= '0;
            end else if (we && (waddr == roff_t'(r))) begin
                store[r] <= wdata;
            end
        end
    end

    assign regs = store;
    assign irq  = gate_irq(src, store[IER_OFF]);

endmodule

// File: rtl/dcbf_rd_mux.sv
module dcbf_rd_mux
    import dcbf_pkg::*;
(
    input  logic                     cs_n,
    input  logic                     rd_n,
    input  logic                     chan_sel,
    input  roff_t                    reg_off,
    input  bank_t [NUM_CH-1:0]       banks,
    output byte_t                    bus_out,
    output logic                     bus_oe
);

    chan_e sel;

    always_comb begin
        sel     = decode_chan(chan_sel);
        bus_oe  = !cs_n && !rd_n;
        bus_out = bus_oe ? banks[sel][reg_off] : '0;
    end

endmodule

// File: rtl/dual_chan_bus_front.sv
module dual_chan_bus_front
    import dcbf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        chan_sel,
    input  logic [2:0]  reg_off,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [7:0]  bus_in,
    output logic [7:0]  bus_out,
    output logic        bus_oe,
    input  logic [4:0]  src_a,
    input  logic [4:0]  src_b,
    output logic        irq_a,
    output logic        irq_b
);

    wr_req_t            req;
    bank_t [NUM_CH-1:0] banks;
    src_t  [NUM_CH-1:0] srcs;
    logic  [NUM_CH-1:0] irqs;
    logic  [NUM_CH-1:0] we;
    logic               bcast;

    // plain views for the bound checker
    logic  commit_pulse;
    bank_t regs_a_v;
    bank_t regs_b_v;

    dcbf_wr_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .chan_sel (chan_sel),
        .reg_off  (reg_off),
        .bus_in   (bus_in),
        .wr_n     (wr_n),
        .req      (req)
    );

    // broadcast is decided by the channel the write was aimed at
    assign bcast = banks[req.chan][AFR_OFF][BCAST_BIT];

    assign srcs[CH_A] = src_a;
    assign srcs[CH_B] = src_b;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign we[c] = req.go && (bcast || (req.chan == chan_e'(c)));

        dcbf_bank u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (we[c]),
            .waddr (req.off),
            .wdata (req.data),
            .src   (srcs[c]),
            .regs  (banks[c]),
            .irq   (irqs[c])
        );
    end

    dcbf_rd_mux u_rd (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .chan_sel (chan_sel),
        .reg_off  (reg_off),
        .banks    (banks),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe)
    );

    assign irq_a = irqs[CH_A];
    assign irq_b = irqs[CH_B];

    assign commit_pulse = req.go;
    assign regs_a_v     = banks[CH_A];
    assign regs_b_v     = banks[CH_B];

endmodule

// File: rtl/dcbf_checker.sv
module dcbf_checker
    import dcbf_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  cs_n,
    input logic  rd_n,
    input logic  wr_n,
    input logic  bus_oe,
    input src_t  src_a,
    input src_t  src_b,
    input logic  irq_a,
    input logic  irq_b,
    input logic  commit_pulse,
    input bank_t regs_a_v,
    input bank_t regs_b_v
);

    // R1: reset clears both banks by the next edge
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (regs_a_v == '0) && (regs_b_v == '0));

    // R2: no bus drive without select
    assert_oe_needs_cs_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !bus_oe);

    // R2: no bus drive without read strobe
    assert_oe_needs_rd_R2: assert property (@(posedge clk) disable iff (rst)
        rd_n |-> !bus_oe);

    // R4: a commit never lasts two cycles
    assert_single_commit_R4: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |=> !commit_pulse);

    // R4: while the strobe is low, no register moves
    assert_hold_low_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> ($stable(regs_a_v) && $stable(regs_b_v)));

    // R4: with the strobe idle across two samples, no register moves
    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_n && $past(wr_n)) |=> ($stable(regs_a_v) && $stable(regs_b_v)));

    // R9: a request needs a pending source
    assert_irq_a_src_R9: assert property (@(posedge clk) disable iff (rst)
        (src_a == '0) |-> !irq_a);

    assert_irq_b_src_R9: assert property (@(posedge clk) disable iff (rst)
        (src_b == '0) |-> !irq_b);

endmodule

bind dual_chan_bus_front dcbf_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .bus_oe       (bus_oe),
    .src_a        (src_a),
    .src_b        (src_b),
    .irq_a        (irq_a),
    .irq_b        (irq_b),
    .commit_pulse (commit_pulse),
    .regs_a_v     (regs_a_v),
    .regs_b_v     (regs_b_v)
);

// File: tb/sim_dual_chan_bus_front.sv
module sim_dual_chan_bus_front;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, chan_sel, rd_n, wr_n;
    logic [2:0] reg_off;
    logic [7:0] bus_in;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [4:0] src_a, src_b;
    logic       irq_a, irq_b;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit running = 0;

    // reference: index 0 is channel A, index 1 is channel B
    logic [7:0] m [2][8];

    always #5 clk = ~clk;

    dual_chan_bus_front u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .chan_sel(chan_sel),
        .reg_off(reg_off), .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .src_a(src_a), .src_b(src_b),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int idx(input logic sel);
        return sel ? 0 : 1;
    endfunction

    // per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (running && !rst) begin
            logic eoe, eia, eib;
            eoe = !cs_n && !rd_n;
            check(bus_oe === eoe, "R2 oe", int'(bus_oe), int'(eoe));
            if (eoe)
                check(bus_out === m[idx(chan_sel)][reg_off], "R3 read data",
                      int'(bus_out), int'(m[idx(chan_sel)][reg_off]));
            eia = |(src_a & m[0][1][4:0]);
            eib = |(src_b & m[1][1][4:0]);
            check(irq_a === eia, "R9 irq_a", int'(irq_a), int'(eia));
            check(irq_b === eib, "R9 irq_b", int'(irq_b), int'(eib));
        end
    end

    task automatic model_write(input logic c, input logic s, input int a, input logic [7:0] d);
        int t;
        if (!c) begin
            t = idx(s);
            if (m[t][2][0]) begin
                m[0][a] = d;
                m[1][a] = d;
            end else begin
                m[t][a] = d;
            end
        end
    endtask

    // one strobe pulse of given length; data may change mid-pulse
    task automatic wr(input logic c, input logic s, input int a,
                      input logic [7:0] d, input int len = 1, input logic [7:0] d_late = 8'h00);
        @(negedge clk);
        cs_n = c; chan_sel = s; reg_off = 3'(a); bus_in = d; wr_n = 1'b0;
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            if (i == len - 1) bus_in = d_late;
        end
        @(negedge clk);
        wr_n = 1'b1;
        model_write(c, s, a, (len > 1) ? d_late : d);
        cs_n = 1'b1;
        @(negedge clk);
        bus_in = ~bus_in;
        @(negedge clk);
    endtask

    task automatic rd(input logic s, input int a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cs_n = 1'b0; chan_sel = s; reg_off = 3'(a); rd_n = 1'b0;
        @(posedge clk);
        #3;
        check(bus_oe === 1'b1 && bus_out === exp, tag, int'(bus_out), int'(exp));
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish");
            summary();
        end
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; chan_sel = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        reg_off = '0; bus_in = '0; src_a = '1; src_b = '1;
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 8; a++) m[c][a] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        running = 1;

        // R1: cleared banks, no requests despite all sources pending
        @(posedge clk); #3;
        check(irq_a === 1'b0 && irq_b === 1'b0, "R1 irq after reset", int'({irq_a, irq_b}), 0);
        for (int a = 0; a < 8; a++) begin
            rd(1'b1, a, 8'h00, "R1 channel A after reset");
            rd(1'b0, a, 8'h00, "R1 channel B after reset");
        end
        src_a = '0; src_b = '0;

        // R2: read strobe without select
        @(negedge clk); rd_n = 1'b0; cs_n = 1'b1;
        @(posedge clk); #3;
        check(bus_oe === 1'b0, "R2 rd without cs", int'(bus_oe), 0);
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b0;
        @(posedge clk); #3;
        check(bus_oe === 1'b0, "R2 cs without rd", int'(bus_oe), 0);
        @(negedge clk); cs_n = 1'b1;

        // R6: single-channel writes
        wr(1'b0, 1'b1, 3, 8'h5A);
        rd(1'b1, 3, 8'h5A, "R6 channel A written");
        rd(1'b0, 3, 8'h00, "R6 channel B untouched");
        wr(1'b0, 1'b0, 3, 8'hC3);
        rd(1'b0, 3, 8'hC3, "R3 channel B read");
        rd(1'b1, 3, 8'h5A, "R3 channel A read");

        // R5: select inactive
        wr(1'b1, 1'b1, 3, 8'hFF);
        rd(1'b1, 3, 8'h5A, "R5 write ignored without cs");

        // R10: every offset distinct (offset 2 keeps bit 0 clear)
        for (int a = 0; a < 8; a++) wr(1'b0, 1'b1, a, 8'(8'h20 + 2 * a));
        for (int a = 0; a < 8; a++) rd(1'b1, a, 8'(8'h20 + 2 * a), "R10 offset read-back A");
        for (int a = 0; a < 8; a++) wr(1'b0, 1'b0, a, 8'(8'hA0 + 2 * a + 16 * (a % 2)));
        for (int a = 0; a < 8; a++) rd(1'b0, a, 8'(8'hA0 + 2 * a + 16 * (a % 2)), "R10 offset read-back B");

        // R4: long strobe, data changes mid-pulse; last low sample wins
        wr(1'b0, 1'b1, 6, 8'h11, 4, 8'h99);
        rd(1'b1, 6, 8'h99, "R4 last sampled data committed");
        @(negedge clk); bus_in = 8'h3C; reg_off = 3'd6; cs_n = 1'b0; chan_sel = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        rd(1'b1, 6, 8'h99, "R4 no update without strobe");

        // R9: enable and source combinations
        wr(1'b0, 1'b1, 1, 8'h01);
        wr(1'b0, 1'b0, 1, 8'h18);
        @(negedge clk); src_a = 5'b00010; src_b = 5'b00111;
        @(posedge clk); #3;
        check(irq_a === 1'b0 && irq_b === 1'b0, "R9 disjoint sources", int'({irq_a, irq_b}), 0);
        @(negedge clk); src_a = 5'b00011; src_b = 5'b10000;
        @(posedge clk); #3;
        check(irq_a === 1'b1 && irq_b === 1'b1, "R9 enabled sources", int'({irq_a, irq_b}), 3);
        @(negedge clk); src_a = '0; src_b = 5'b01000;
        @(posedge clk); #3;
        check(irq_a === 1'b0 && irq_b === 1'b1, "R9 per-channel gating", int'({irq_a, irq_b}), 1);
        @(negedge clk); src_b = '0;

        // R7: broadcast from channel A
        wr(1'b0, 1'b1, 2, 8'h01);
        wr(1'b0, 1'b1, 5, 8'h77);
        rd(1'b1, 5, 8'h77, "R7 broadcast reaches A");
        rd(1'b0, 5, 8'h77, "R7 broadcast reaches B");
        // R7: B addressed, B's bit clear, A's bit set -> no broadcast
        wr(1'b0, 1'b0, 5, 8'h88);
        rd(1'b0, 5, 8'h88, "R7 B-only write");
        rd(1'b1, 5, 8'h77, "R7 A unaffected by B write");
        // R8: reads stay per channel while broadcast is on
        rd(1'b1, 3, m[0][3], "R8 read A with broadcast on");
        rd(1'b0, 3, m[1][3], "R8 read B with broadcast on");
        // clearing from A broadcasts the clear too
        wr(1'b0, 1'b1, 2, 8'h40);
        rd(1'b0, 2, 8'h40, "R7 broadcast clear reaches B");
        wr(1'b0, 1'b1, 7, 8'h5E);
        rd(1'b0, 7, m[1][7], "R6 broadcast off again");
        rd(1'b1, 7, 8'h5E, "R6 A written after clear");

        repeat (3) @(negedge clk);
        running = 0;
        summary();
    end

endmodule